// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of one memory read or write burst. A single-cycle start request carries the starting column address, the burst length and the ordering mode. The block then presents one column address per clock cycle, with a valid flag and a flag on the final beat. Only the lowest bits of the address move during a burst: one bit for a two-beat burst, two bits for four beats and three bits for eight beats. All higher bits keep their starting value.

Two orderings are available, and the mode is chosen for each burst. Wrapping order counts the moving bits upward from the start offset and wraps inside the aligned block. Interleaved order forms each beat's moving bits as the start offset XOR the beat number. When the start offset is zero, both orderings give plain ascending order. For two-beat bursts, the two orderings are the same.

A command sequencer in a DRAM controller uses the block to turn one column command into per-beat addresses. A new request may be given in the same cycle that the final beat is shown, so bursts can run back to back. A request made while a burst is still in progress is ignored.

Top module: `burst_colgen`

## Requirements
- R1: The length select `bl_sel_i` is decoded as 2'b00 = 2 beats, 2'b01 = 4 beats, 2'b10 = 8 beats, and the reserved code 2'b11 = 8 beats. An accepted request yields exactly that many beats with `valid_o` high.
- R2: With `ilv_i` = 0 (wrapping order), beat i carries the moving bits (off + i) mod L. Here L is the burst length and off is the start column's moving bits.
- R3: With `ilv_i` = 1 (interleaved order), beat i carries the moving bits off XOR i.
- R4: Every address bit above the moving bits equals the corresponding bit of the start column on every beat of the burst.
- R5: A request is accepted on a rising edge where `start_i` = 1 and `busy_o` = 0. The first beat appears in the following cycle, and its address equals the start column.
- R6: `last_o` is high only together with `valid_o` on the final beat. In the next cycle `valid_o` is low, unless a new request was accepted on that edge.
- R7: `busy_o` is high during every beat of a burst except the final one. A request made while `busy_o` is high is ignored: no extra beats appear and the running burst keeps its addresses.
- R8: Length, mode and start column are captured on acceptance. Changing those inputs during a burst has no effect on it.
- R9: While reset is asserted and right after it, `valid_o`, `last_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, sampled when `busy_o` is low |
| col_i | input | COL_W | Starting column address |
| bl_sel_i | input | 2 | Length select: 00 = 2, 01 = 4, 10/11 = 8 beats |
| ilv_i | input | 1 | Ordering: 0 = wrapping, 1 = interleaved |
| addr_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The presented beat is the final one |
| busy_o | output | 1 | Burst in progress with more beats to follow |

## Verification
The bench builds the block with the default ten-bit column. This leaves seven fixed high bits, so it can show that bits above the moving field never change while the low field wraps or is XORed. Every one of the eight start offsets is run with every length code (including the reserved one) in both orderings. The high bits differ from burst to burst, and the bursts are issued back to back. During the bursts the bench also changes the length, mode and column inputs, and gives a request while the block is busy.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  // widest moving field (eight-beat burst)
  localparam int unsigned FIELD_W = 3;

  typedef enum logic [1:0] {
    BL_TWO   = 2'b00,
    BL_FOUR  = 2'b01,
    BL_EIGHT = 2'b10,
    BL_RSVD  = 2'b11
  } bl_sel_e;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;

  // mask of moving bits; equals burst length minus one
  function automatic logic [FIELD_W-1:0] field_mask(input bl_sel_e sel);
    case (sel)
      BL_TWO:  field_mask = 3'b001;
      BL_FOUR: field_mask = 3'b011;
      default: field_mask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/burst_colgen_ctrl.sv
module burst_colgen_ctrl
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COL_W-1:0]   col_i,
  input  bl_sel_e            bl_sel_i,
  input  order_e             order_i,
  output logic               active_o,
  output logic [FIELD_W-1:0] beat_o,
  output logic [FIELD_W-1:0] mask_o,
  output order_e             order_o,
  output logic [COL_W-1:0]   base_o,
  output logic               last_o,
  output logic               busy_o
);

  logic               active_q, active_d;
  logic [FIELD_W-1:0] beat_q, beat_d;
  logic [FIELD_W-1:0] mask_q, mask_d;
  order_e             order_q, order_d;
  logic [COL_W-1:0]   base_q, base_d;
  logic               last_beat;
  logic               accept;
  logic               en_cap;
  logic               en_beat;

  assign last_beat = active_q && (beat_q == mask_q);
  assign busy_o    = active_q && !last_beat;
  assign accept    = start_i && !busy_o;
  assign en_cap    = accept;
  assign en_beat   = accept || active_q;

  // next-state
  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    mask_d   = mask_q;
    order_d  = order_q;
    base_d   = base_q;
    if (accept) begin
      active_d = 1'b1;
      beat_d   = '0;
      mask_d   = field_mask(bl_sel_i);
      order_d  = order_i;
      base_d   = col_i;
    end else if (last_beat) begin
      active_d = 1'b0;
    end else if (active_q) begin
      beat_d   = beat_q + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (en_beat) begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  // burst parameters, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      order_q <= ORD_WRAP;
      base_q  <= '0;
    end else if (en_cap) begin
      mask_q  <= mask_d;
      order_q <= order_d;
      base_q  <= base_d;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign order_o  = order_q;
  assign base_o   = base_q;
  assign last_o   = last_beat;

endmodule

// File: rtl/burst_colgen_order.sv
module burst_colgen_order
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] beat_i,
  input  order_e             order_i,
  output logic [COL_W-1:0]   addr_o
);

  localparam int unsigned HI_W = COL_W - FIELD_W;

  logic [FIELD_W-1:0] off;
  logic [FIELD_W-1:0] low;

  assign off = base_i[FIELD_W-1:0];

  // wrapping: add then keep masked bits; interleave: XOR
  always_comb begin
    if (order_i == ORD_XOR) low = off ^ beat_i;
    else                    low = off + beat_i;
  end

  // per-bit select between moving value and fixed start bit
  for (genvar g = 0; g < FIELD_W; g++) begin : g_field
    assign addr_o[g] = mask_i[g] ? low[g] : base_i[g];
  end

  if (HI_W > 0) begin : g_high
    assign addr_o[COL_W-1:FIELD_W] = base_i[COL_W-1:FIELD_W];
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_sel_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);

  logic               active;
  logic [FIELD_W-1:0] beat;
  logic [FIELD_W-1:0] mask;
  order_e             order;
  logic [COL_W-1:0]   base;

  burst_colgen_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .col_i    (col_i),
    .bl_sel_i (bl_sel_e'(bl_sel_i)),
    .order_i  (order_e'(ilv_i)),
    .active_o (active),
    .beat_o   (beat),
    .mask_o   (mask),
    .order_o  (order),
    .base_o   (base),
    .last_o   (last_o),
    .busy_o   (busy_o)
  );

  burst_colgen_order #(.COL_W(COL_W)) order_i (
    .base_i  (base),
    .mask_i  (mask),
    .beat_i  (beat),
    .order_i (order),
    .addr_o  (addr_o)
  );

  assign valid_o = active;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] addr_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             busy_o
);

  // R5: accepted request shows its start column on the next cycle
  a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> valid_o && (addr_o == $past(col_i)));

  // R6: final-beat flag only with a valid beat
  a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R6: output goes quiet after the final beat unless restarted
  a_r6_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);

  // R7: busy means more beats follow
  a_r7_busy_continues: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> valid_o);

  // R7, R4: request while busy leaves the fixed bits untouched
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(addr_o[COL_W-1:3]));

  // R9: no flags without a beat
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !last_o && !busy_o);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .col_i   (col_i),
  .addr_o  (addr_o),
  .valid_o (valid_o),
  .last_o  (last_o),
  .busy_o  (busy_o)
);

// File: tb/burst_colgen_tb_top.sv
module burst_colgen_tb_top;

  localparam int unsigned COL_W  = 10;
  localparam time         PERIOD = 10ns;

  typedef struct {
    logic [COL_W-1:0] addr;
    logic             last;
    string            tag;
  } beat_t;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] col_i;
  logic [1:0]       bl_sel_i;
  logic             ilv_i;
  logic [COL_W-1:0] addr_o;
  logic             valid_o;
  logic             last_o;
  logic             busy_o;

  int    n_checks;
  int    n_fails;
  bit    done;
  beat_t exp_q[$];

  burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .col_i    (col_i),
    .bl_sel_i (bl_sel_i),
    .ilv_i    (ilv_i),
    .addr_o   (addr_o),
    .valid_o  (valid_o),
    .last_o   (last_o),
    .busy_o   (busy_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each presented beat
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6,R7 unexpected beat", longint'(addr_o), 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check(addr_o == e.addr, e.tag, longint'(addr_o), longint'(e.addr));
        check(last_o == e.last, "R1,R6 last flag", longint'(last_o), longint'(e.last));
      end
    end
  end

  // driver: wait for a free slot, queue the reference order, pulse start
  task automatic send(input logic [COL_W-1:0] col, input logic [1:0] bl, input logic il);
    int unsigned len;
    int unsigned off;
    logic [COL_W-1:0] hi;
    while (busy_o) @(negedge clk);
    len = (bl == 2'b00) ? 2 : (bl == 2'b01) ? 4 : 8;
    off = int'(col) % len;
    hi  = col & ~COL_W'(len - 1);
    for (int i = 0; i < int'(len); i++) begin
      beat_t b;
      int unsigned low;
      low    = il ? (off ^ i) : ((off + i) % len);
      b.addr = hi | COL_W'(low);
      b.last = (i == int'(len) - 1);
      b.tag  = il ? "R1,R3,R4,R8 interleaved" : "R1,R2,R4,R8 wrapping";
      exp_q.push_back(b);
    end
    start_i  = 1'b1;
    col_i    = col;
    bl_sel_i = bl;
    ilv_i    = il;
    @(negedge clk);
    start_i  = 1'b0;
    // R5: first beat one cycle after acceptance
    check(valid_o && addr_o == col, "R5 first beat", longint'(addr_o), longint'(col));
    // R8: disturb the captured inputs
    col_i    = ~col;
    bl_sel_i = bl + 2'd1;
    ilv_i    = ~il;
  endtask

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    col_i    = '0;
    bl_sel_i = 2'b00;
    ilv_i    = 1'b0;
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    check(!valid_o && !last_o && !busy_o, "R9 in reset", longint'({valid_o, last_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid_o && !last_o && !busy_o, "R9 after reset", longint'({valid_o, last_o, busy_o}), 0);

    // every length code, mode and start offset, back to back
    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 2; m++) begin
        for (int o = 0; o < 8; o++) begin
          logic [COL_W-1:0] c;
          c = (COL_W'(b * 149 + m * 83 + o * 29 + 40) & ~COL_W'(7)) | COL_W'(o);
          send(c, 2'(b), m[0]);
        end
      end
    end

    // R7: request while busy is ignored
    send(COL_W'(10'h2B5), 2'b10, 1'b0);
    start_i  = 1'b1;
    col_i    = COL_W'(10'h0C3);
    bl_sel_i = 2'b00;
    ilv_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy mid-burst", longint'(busy_o), 1);

    // R6: drain and confirm quiet output
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!valid_o && !busy_o && !last_o, "R6 idle after burst", longint'({valid_o, busy_o, last_o}), 0);
    check(exp_q.size() == 0, "R7 no missing beats", longint'(exp_q.size()), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1..R9 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule